// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a small programmable logic core. Eight dedicated data inputs, eight pin feedback lines and two general pins feed a programmable AND plane of 64 product terms. A fixed OR plane gives each of the eight output cells its own group of eight terms. Each output cell turns its sum into a pin value and a pin enable. A cell can be combinational or registered, and its output polarity is selectable. Its enable can come from an always-on setting, a shared enable pin or its first product term.

The AND plane and the cell modes sit in a configuration store. A parallel write port fills that store after reset. Row 64 of the store holds the mode bits: one device-wide synchronous flag, one device-wide alternate flag, and one local bit per cell. These three bits together pick the output path, the enable source and the feedback source of every cell.

For test, a preload strobe forces all output registers to a given byte in any mode. Reset clears every register.

Top module: `pal_sop_core`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` on the rising clock edge. Addresses 0 to 63 select AND rows. Address 64 selects the mode row, where bits [7:0] are the local bits (L), [15:8] the polarity bits, bit 16 the synchronous flag (S) and bit 17 the alternate flag (A). Addresses above 64 change nothing. After reset every AND cell is connected and every mode bit is 0.
- R2: Array column j has its true literal at row bit 2j and its complement at bit 2j+1. Columns 0-7 are `din`, 8-15 are cell feedback 0-7, and 16-17 are `gin[0]` and `gin[1]`. A product term is the AND of its connected literals, so a row with every cell connected gives 0. Term k of cell m is row 8m+k.
- R3: With polarity bit 0 a cell passes its sum unchanged. With polarity bit 1 it inverts the sum. A registered cell stores the polarity-adjusted sum.
- R4: Simple mode is S=1, A=0. A cell with L=0 drives its combinational value (OR of all 8 terms), always enabled. A cell with L=1 is input-only, with its enable at 0. In this mode, feedback m is taken from pin `io_in[m^1]`.
- R5: This requirement covers complex mode (S=1, A=1) and cells with L=1 in registered mode (S=0). Each such cell is combinational, with enable = term 0 and sum = OR of terms 1-7. Its feedback is its own pin `io_in[m]`.
- R6: Registered mode is S=0, and A is not examined. A cell with L=0 drives its register, with enable = `!gin[1]`. The register loads on a clock edge with `gin[0]`=1 and holds otherwise. Its feedback is the register's inverse.
- R7: With S=0, both literals of columns 16 and 17 are ignored: connected or not, they never clear a term.
- R8: `pl_en` high loads `pl_data` into all eight registers on the next edge. This happens in every mode and takes priority over a normal load.
- R9: `rst_n` low clears every output register and the configuration at once. After release, the block stays in reset for two more rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration row address |
| cfg_wdata | input | 36 | Configuration row data |
| din | input | 8 | Dedicated array inputs |
| gin | input | 2 | General pins: register load enable / shared output enable in registered mode, array inputs otherwise |
| io_in | input | 8 | Pin readback used as feedback |
| pl_en | input | 1 | Register preload strobe |
| pl_data | input | 8 | Register preload value |
| io_out | output | 8 | Cell output values |
| io_oe | output | 8 | Cell output enables |

## Verification
The hardest situation to reach from the ports is a registered cell whose next state depends on its own inverted register through the array. In that situation a wrong feedback source only shows up several cycles later. It is also easily masked by the general pins, which stop being array inputs in this mode. The stimulus writes random sparse AND rows and then runs hundreds of cycles in registered mode, with random load enables and occasional preloads. This lets feedback chains build up. Directed rows that connect only general-pin literals, together with a preload followed by a mode switch, cover the ignore and priority cases.

// File: rtl/pal_sop_pkg.sv
package pal_sop_pkg;

  localparam int N_GIN     = 2;
  localparam int GIN_LDEN  = 0;
  localparam int GIN_OE    = 1;

  typedef enum logic [1:0] {
    MC_SIMPLE  = 2'd0,
    MC_COMPLEX = 2'd1,
    MC_REG     = 2'd2
  } arch_e;

  function automatic arch_e decode_arch(input logic syn, input logic ac0);
    if (!syn)    return MC_REG;
    else if (ac0) return MC_COMPLEX;
    else          return MC_SIMPLE;
  endfunction

endpackage

// File: rtl/pal_sop_cfg.sv
module pal_sop_cfg #(
  parameter int N_ROW  = 64,
  parameter int ROW_W  = 36,
  parameter int MODE_W = 18,
  parameter int AW     = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [AW-1:0]                addr,
  input  logic [ROW_W-1:0]             wdata,
  output logic [N_ROW-1:0][ROW_W-1:0]  rows,
  output logic [MODE_W-1:0]            mode
);

  logic [N_ROW-1:0] row_en;
  logic             mode_en;

  always_comb begin
    for (int r = 0; r < N_ROW; r++) row_en[r] = we && (addr == AW'(r));
    mode_en = we && (addr == AW'(N_ROW));
  end

  for (genvar r = 0; r < N_ROW; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rows[r] <= '1;
      else if (row_en[r]) rows[r] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode <= '0;
    else if (mode_en) mode <= wdata[MODE_W-1:0];
  end

endmodule

// File: rtl/pal_sop_and.sv
module pal_sop_and #(
  parameter int N_COL = 18,
  parameter int N_PT  = 64
) (
  input  logic [N_COL-1:0]                  col_val,
  input  logic [N_COL-1:0]                  col_ign,
  input  logic [N_PT-1:0][2*N_COL-1:0]      rows,
  output logic [N_PT-1:0]                   pt
);

  for (genvar p = 0; p < N_PT; p++) begin : g_pt
    logic term;
    always_comb begin
      term = 1'b1;
      for (int j = 0; j < N_COL; j++) begin
        if (!col_ign[j]) begin
          if (rows[p][2*j]   && !col_val[j]) term = 1'b0;
          if (rows[p][2*j+1] &&  col_val[j]) term = 1'b0;
        end
      end
    end
    assign pt[p] = term;
  end

endmodule

// File: rtl/pal_sop_mc.sv
module pal_sop_mc
  import pal_sop_pkg::*;
#(
  parameter int PT_N = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  arch_e           arch,
  input  logic            ac1,
  input  logic            pol,
  input  logic [PT_N-1:0] pt,
  input  logic            pin_self,
  input  logic            pin_adj,
  input  logic            ld_en,
  input  logic            oe_pin_n,
  input  logic            pl_en,
  input  logic            pl_bit,
  output logic            out,
  output logic            oe,
  output logic            fb,
  output logic            q
);

  logic q_r, q_d;
  logic use_reg, pt0_oe, sum_sel, d_val;

  always_comb begin
    use_reg = (arch == MC_REG) && !ac1;
    pt0_oe  = (arch == MC_COMPLEX) || ((arch == MC_REG) && ac1);
    sum_sel = pt0_oe ? |pt[PT_N-1:1] : |pt;
    d_val   = sum_sel ^ pol;
    q_d     = q_r;
    if (pl_en)                q_d = pl_bit;
    else if (use_reg && ld_en) q_d = d_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  always_comb begin
    out = use_reg ? q_r : d_val;
    if (use_reg)                oe = !oe_pin_n;
    else if (pt0_oe)            oe = pt[0];
    else if (arch == MC_SIMPLE) oe = !ac1;
    else                        oe = 1'b0;
    if (use_reg)                fb = !q_r;
    else if (arch == MC_SIMPLE) fb = pin_adj;
    else                        fb = pin_self;
  end

  assign q = q_r;

endmodule

// File: rtl/pal_sop_core.sv
module pal_sop_core
  import pal_sop_pkg::*;
#(
  parameter  int N_DIN     = 8,
  parameter  int N_MC      = 8,
  parameter  int PT_PER_MC = 8,
  localparam int N_COL     = N_DIN + N_MC + N_GIN,
  localparam int N_LIT     = 2 * N_COL,
  localparam int N_PT      = N_MC * PT_PER_MC,
  localparam int AW        = $clog2(N_PT + 1),
  localparam int MODE_W    = 2 * N_MC + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [N_LIT-1:0]  cfg_wdata,
  input  logic [N_DIN-1:0]  din,
  input  logic [N_GIN-1:0]  gin,
  input  logic [N_MC-1:0]   io_in,
  input  logic              pl_en,
  input  logic [N_MC-1:0]   pl_data,
  output logic [N_MC-1:0]   io_out,
  output logic [N_MC-1:0]   io_oe
);

  // reset: asserted at once, released after two edges
  logic [1:0] rst_sync;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  logic [N_PT-1:0][N_LIT-1:0] and_rows;
  logic [MODE_W-1:0]          mode_row;

  pal_sop_cfg #(
    .N_ROW (N_PT),
    .ROW_W (N_LIT),
    .MODE_W(MODE_W),
    .AW    (AW)
  ) u_cfg (
    .clk  (clk),
    .rst_n(rst_s),
    .we   (cfg_we),
    .addr (cfg_addr),
    .wdata(cfg_wdata),
    .rows (and_rows),
    .mode (mode_row)
  );

  logic [N_MC-1:0] ac1, pol;
  logic            syn, ac0;
  arch_e           arch;

  always_comb begin
    ac1  = mode_row[N_MC-1:0];
    pol  = mode_row[2*N_MC-1:N_MC];
    syn  = mode_row[2*N_MC];
    ac0  = mode_row[2*N_MC+1];
    arch = decode_arch(syn, ac0);
  end

  logic [N_MC-1:0]  fb_all;
  logic [N_MC-1:0]  q_all;
  logic [N_COL-1:0] col_val, col_ign;
  logic [N_PT-1:0]  pt_all;

  always_comb begin
    col_val = {gin, fb_all, din};
    col_ign = {{N_GIN{arch == MC_REG}}, {(N_DIN + N_MC){1'b0}}};
  end

  pal_sop_and #(
    .N_COL(N_COL),
    .N_PT (N_PT)
  ) u_and (
    .col_val(col_val),
    .col_ign(col_ign),
    .rows   (and_rows),
    .pt     (pt_all)
  );

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    localparam int ADJ = ((m ^ 1) < N_MC) ? (m ^ 1) : m;
    pal_sop_mc #(
      .PT_N(PT_PER_MC)
    ) u_mc (
      .clk     (clk),
      .rst_n   (rst_s),
      .arch    (arch),
      .ac1     (ac1[m]),
      .pol     (pol[m]),
      .pt      (pt_all[m*PT_PER_MC +: PT_PER_MC]),
      .pin_self(io_in[m]),
      .pin_adj (io_in[ADJ]),
      .ld_en   (gin[GIN_LDEN]),
      .oe_pin_n(gin[GIN_OE]),
      .pl_en   (pl_en),
      .pl_bit  (pl_data[m]),
      .out     (io_out[m]),
      .oe      (io_oe[m]),
      .fb      (fb_all[m]),
      .q       (q_all[m])
    );
  end

endmodule

// File: rtl/pal_sop_core_chk.sv
module pal_sop_core_chk #(
  parameter int N_MC     = 8,
  parameter int N_LIT    = 36,
  parameter int AW       = 7,
  parameter int MODE_ROW = 64
) (
  input logic             clk,
  input logic             rst_s,
  input logic             cfg_we,
  input logic [AW-1:0]    cfg_addr,
  input logic [N_LIT-1:0] cfg_wdata,
  input logic [N_MC-1:0]  ac1,
  input logic [N_MC-1:0]  pol,
  input logic             syn,
  input logic             ac0,
  input logic [1:0]       gin,
  input logic             pl_en,
  input logic [N_MC-1:0]  pl_data,
  input logic [N_MC-1:0]  q,
  input logic [N_MC-1:0]  io_oe
);

  a_r1_mode_write: assert property (@(posedge clk) disable iff (!rst_s)
    (cfg_we && cfg_addr == AW'(MODE_ROW)) |=>
      ({ac0, syn, pol, ac1} == $past(cfg_wdata[2*N_MC+1:0])));

  a_r8_preload: assert property (@(posedge clk) disable iff (!rst_s)
    pl_en |=> (q == $past(pl_data)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (!pl_en && !gin[0]) |=> $stable(q));

  a_r4_input_only: assert property (@(posedge clk) disable iff (!rst_s)
    (syn && !ac0) |-> ((ac1 & io_oe) == '0));

  a_r6_oe_pin: assert property (@(posedge clk) disable iff (!rst_s)
    (!syn) |-> ((~ac1 & io_oe) == (~ac1 & {N_MC{!gin[1]}})));

endmodule

bind pal_sop_core pal_sop_core_chk #(
  .N_MC    (N_MC),
  .N_LIT   (N_LIT),
  .AW      (AW),
  .MODE_ROW(N_PT)
) u_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .cfg_wdata(cfg_wdata),
  .ac1      (ac1),
  .pol      (pol),
  .syn      (syn),
  .ac0      (ac0),
  .gin      (gin),
  .pl_en    (pl_en),
  .pl_data  (pl_data),
  .q        (q_all),
  .io_oe    (io_oe)
);

// File: tb/pal_sop_core_bench.sv
`timescale 1ns/1ps
module pal_sop_core_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [6:0]  cfg_addr;
  logic [35:0] cfg_wdata;
  logic [7:0]  din;
  logic [1:0]  gin;
  logic [7:0]  io_in;
  logic        pl_en;
  logic [7:0]  pl_data;
  logic [7:0]  io_out, io_oe;

  always #2 clk = ~clk;

  pal_sop_core u_pal_sop_core (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .din(din), .gin(gin), .io_in(io_in),
    .pl_en(pl_en), .pl_data(pl_data), .io_out(io_out), .io_oe(io_oe)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  logic [35:0] m_rows [64];
  logic [7:0]  m_ac1, m_pol, mq;
  logic        m_syn, m_ac0;
  logic [7:0]  e_out, e_oe, e_next;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < 64; r++) m_rows[r] = '1;
    m_ac1 = '0; m_pol = '0; m_syn = 1'b0; m_ac0 = 1'b0; mq = '0;
  endtask

  task automatic model();
    logic [7:0]  fb;
    logic [17:0] cv;
    logic [63:0] pt;
    bit regm, simp, cplx, ureg, p0;
    logic s, d;
    regm = !m_syn; simp = m_syn && !m_ac0; cplx = m_syn && m_ac0;
    for (int m = 0; m < 8; m++) begin
      if (regm && !m_ac1[m]) fb[m] = ~mq[m];
      else if (simp)         fb[m] = io_in[m ^ 1];
      else                   fb[m] = io_in[m];
    end
    cv = {gin, fb, din};
    for (int p = 0; p < 64; p++) begin
      pt[p] = 1'b1;
      for (int j = 0; j < 18; j++) begin
        if (!(regm && j >= 16)) begin
          if (m_rows[p][2*j]   && !cv[j]) pt[p] = 1'b0;
          if (m_rows[p][2*j+1] &&  cv[j]) pt[p] = 1'b0;
        end
      end
    end
    for (int m = 0; m < 8; m++) begin
      ureg = regm && !m_ac1[m];
      p0   = cplx || (regm && m_ac1[m]);
      s    = p0 ? |pt[8*m+1 +: 7] : |pt[8*m +: 8];
      d    = s ^ m_pol[m];
      e_out[m]  = ureg ? mq[m] : d;
      e_oe[m]   = ureg ? !gin[1] : p0 ? pt[8*m] : simp ? !m_ac1[m] : 1'b0;
      e_next[m] = pl_en ? pl_data[m] : (ureg && gin[0]) ? d : mq[m];
    end
  endtask

  // called just after a falling edge with inputs set
  task automatic step(input string tag);
    #1;
    model();
    chk(io_out === e_out, {tag, " io_out"}, io_out, e_out);
    chk(io_oe  === e_oe,  {tag, " io_oe"},  io_oe,  e_oe);
    @(posedge clk);
    mq = e_next;
    if (cfg_we) begin
      if (cfg_addr < 7'd64) m_rows[cfg_addr[5:0]] = cfg_wdata;
      else if (cfg_addr == 7'd64) {m_ac0, m_syn, m_pol, m_ac1} = cfg_wdata[17:0];
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [35:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step("R1 write");
    cfg_we = 1'b0;
  endtask

  task automatic set_mode(input logic syn, input logic ac0, input logic [7:0] ac1, input logic [7:0] pol);
    wr(7'd64, {18'd0, ac0, syn, pol, ac1});
  endtask

  function automatic logic [35:0] rand_row();
    logic [35:0] r;
    if ($urandom % 6 == 0) return '1;
    r = '0;
    for (int j = 0; j < 18; j++) begin
      int k;
      k = $urandom % 10;
      if (k == 0)      r[2*j]   = 1'b1;
      else if (k == 1) r[2*j+1] = 1'b1;
    end
    return r;
  endfunction

  task automatic randomize_inputs(input bit with_pl);
    din   = 8'($urandom);
    gin   = 2'($urandom);
    io_in = 8'($urandom);
    pl_en = with_pl && ($urandom % 8 == 0);
    pl_data = 8'($urandom);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 8'h0, 8'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    din = '0; gin = 2'b00; io_in = '0; pl_en = 1'b0; pl_data = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state, default registered mode with enable pin low
    chk(io_out === 8'h00, "R9 reset out", io_out, 8'h00);
    chk(io_oe  === 8'hFF, "R6 reset oe",  io_oe,  8'hFF);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R1: reset config (all cells connected, mode zero)
    for (int i = 0; i < 4; i++) begin
      din = 8'($urandom); io_in = 8'($urandom); gin = 2'(i);
      step("R1 default");
    end

    // R2 R3 R4: simple mode directed
    wr(7'd0,  36'h1);             // cell0 t0 = din0
    wr(7'd8,  36'h8);             // cell1 t0 = !din1
    wr(7'd16, 36'h1 << 20);       // cell2 t0 = feedback col 10
    wr(7'd56, 36'h1);             // cell7 row, input-only anyway
    set_mode(1'b1, 1'b0, 8'h80, 8'h02);
    for (int i = 0; i < 4; i++) begin
      din = 8'(i); io_in = 8'($urandom);
      step("R2 R3 literal/polarity");
    end
    io_in = 8'h08; step("R4 adjacent feedback");
    io_in = 8'h04; step("R4 adjacent feedback");
    chk(io_oe[7] === 1'b0, "R4 input-only oe", {7'd0, io_oe[7]}, 8'h00);

    // R5: complex mode, random array
    for (int p = 0; p < 64; p++) wr(7'(p), rand_row());
    set_mode(1'b1, 1'b1, 8'($urandom), 8'($urandom));
    for (int i = 0; i < 150; i++) begin
      randomize_inputs(1'b0);
      step("R5 complex");
    end

    // R5 R6 R8: registered mode, mixed cells
    set_mode(1'b0, 1'($urandom), 8'h0F, 8'($urandom));
    for (int i = 0; i < 300; i++) begin
      randomize_inputs(1'b1);
      step("R6 registered");
    end
    pl_en = 1'b0;
    set_mode(1'b0, 1'b0, 8'h00, 8'h00);
    for (int i = 0; i < 200; i++) begin
      randomize_inputs(1'b1);
      step("R6 all registered");
    end
    pl_en = 1'b0;

    // R7: term made only of general-pin literals
    wr(7'd0, 36'hF << 32);
    for (int i = 0; i < 8; i++) begin
      gin = 2'(i); din = 8'($urandom); io_in = 8'($urandom);
      step("R7 gin ignored");
    end

    // R8: preload in simple mode, then hold in registered mode
    gin = 2'b00;
    set_mode(1'b1, 1'b0, 8'h00, 8'h00);
    pl_en = 1'b1; pl_data = 8'hA5;
    step("R8 preload");
    pl_en = 1'b0;
    set_mode(1'b0, 1'b0, 8'h00, 8'h00);
    step("R8 hold");
    #1;
    chk(io_out === 8'hA5, "R8 preloaded value", io_out, 8'hA5);
    @(negedge clk);

    // R1: out-of-range address ignored
    wr(7'd100, '1);
    wr(7'd127, '0);
    for (int i = 0; i < 6; i++) begin
      randomize_inputs(1'b0);
      step("R1 ignored addr");
    end

    // R9: asynchronous reset mid-run
    gin = 2'b10;
    #1 rst_n = 1'b0;
    #0.5;
    chk(io_out === 8'h00, "R9 async clear", io_out, 8'h00);
    chk(io_oe  === 8'h00, "R9 async oe",    io_oe,  8'h00);
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      randomize_inputs(1'b0);
      step("R9 after reset");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule